// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of general-purpose input pins and decides, for each pin, whether the pin is raising an interrupt. Each pin has its own 4-bit detection code. The top bit of the code is an edge enable. Depending on the code, a pin is sensitive to a low level or a high level, to a rising edge, a falling edge or either edge, or it is switched off.

Pin inputs pass through a two-flop synchronizer before any decision is made. Level modes report the synchronized level directly. Edge modes latch a detected edge into a sticky status bit, and software clears that bit by writing 1 to it.

Each pin's status, gated by a per-pin enable from the interrupt aggregator, forms that pin's interrupt request. There are two bank-wide outputs:
- A wake request, which only edge-mode pins can drive, for restarting a stopped oscillator.
- A clock request, which keeps the module clock running while any enabled detection has an active condition.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every pin's code is 0000 (low level), the synchronizer flops preset to 1, and with all pins held high, `irq_req`, `wake_req` and `clk_req` are all 0.
- R2: Code 0000 reports a pin that is low, and code 0001 reports a pin that is high. In both, the status follows the synchronized level, so `irq_req` responds on the second rising clock edge after the pin changes and drops again when the level goes away.
- R3: Code 1101 detects rising edges, 1110 falling edges and 1111 both edges. `irq_req` asserts on the third rising clock edge after the pin changes. An edge of the opposite direction is not detected in 1101 or 1110.
- R4: In an edge mode the status is sticky. It stays set after the pin returns and is cleared when `clr_we` is high with `clr_mask` bit i set. If an edge is detected in the same cycle as the clear, the set wins. A clear has no effect in a level mode.
- R5: Code 0100, and every code other than 0000, 0001, 1101, 1110 and 1111, produces no interrupt, wake or clock request for the pin, whatever the pin does.
- R6: `irq_req[i]` is the pin's status ANDed with `agg_en[i]`.
- R7: `wake_req` is asserted only by a pin that is in an edge mode, has its sticky status set and has `agg_en[i]` high. Level modes never wake.
- R8: `clk_req` is high while any pin with an active detection mode has its status set, independent of `agg_en`.
- R9: A write to a pin's code (`cfg_we` with `cfg_sel` = i) clears that pin's sticky status and ignores any edge in the write cycle. The new mode applies from the next cycle, so switching modes cannot create an edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_in | input | NUM_PINS (4) | Raw asynchronous pin levels |
| agg_en | input | NUM_PINS (4) | Per-pin enable from the interrupt aggregator |
| cfg_we | input | 1 | Write strobe for one pin's detection code |
| cfg_sel | input | SEL_W (2) | Index of the pin being configured |
| cfg_wdata | input | 4 | Detection code; bit 3 is the edge enable |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | NUM_PINS (4) | Write-1-to-clear mask for sticky status |
| irq_req | output | NUM_PINS (4) | Per-pin interrupt request to the aggregator |
| wake_req | output | 1 | Oscillator wake request, edge modes only |
| clk_req | output | 1 | Module clock ungate request |

## Verification
A corrupted code register or a wrong decode shows up within three clock edges of the next pin transition. The symptom is a missing or spurious `irq_req` bit, or a `clk_req` that disagrees with it. A stale previous-value flop shows up as an edge reported in the wrong direction, or after a code write, on the third edge after the pin moves. A sticky bit that fails to hold or to clear is visible on `irq_req` and `wake_req` on the cycle after the clear strobe, or the cycle after the pin returns.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    DET_OFF,
    DET_LOW,
    DET_HIGH,
    DET_RISE,
    DET_FALL,
    DET_BOTH
  } det_mode_e;

  localparam int CODE_W = 4;

  // Map a 4-bit detection code to a mode; any unlisted code is off.
  function automatic det_mode_e decode_mode(input logic [CODE_W-1:0] code);
    det_mode_e m;
    case (code)
      4'b0000: m = DET_LOW;
      4'b0001: m = DET_HIGH;
      4'b1101: m = DET_RISE;
      4'b1110: m = DET_FALL;
      4'b1111: m = DET_BOTH;
      default: m = DET_OFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int          WIDTH   = 4,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= {WIDTH{RST_VAL}};
      stage2_q <= {WIDTH{RST_VAL}};
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;

endmodule

// File: rtl/gpio_pin_det.sv
module gpio_pin_det
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_s,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_wdata,
  input  logic              clr,
  input  logic              agg_en,
  output logic              irq,
  output logic              wake,
  output logic              clkreq,
  output logic              is_edge
);

  logic [CODE_W-1:0] code_q, code_d;
  logic              prev_q, prev_d;
  logic              sticky_q, sticky_d;
  det_mode_e         mode;
  logic              rise, fall, hit, lvl_stat, status;

  // Decode and event detection
  always_comb begin
    mode     = decode_mode(code_q);
    rise     = pin_s & ~prev_q;
    fall     = ~pin_s & prev_q;
    is_edge  = (mode == DET_RISE) || (mode == DET_FALL) || (mode == DET_BOTH);
    hit      = ((mode == DET_RISE) && rise) ||
               ((mode == DET_FALL) && fall) ||
               ((mode == DET_BOTH) && (rise || fall));
    lvl_stat = ((mode == DET_LOW)  && !pin_s) ||
               ((mode == DET_HIGH) &&  pin_s);
  end

  // Next state
  always_comb begin
    code_d   = cfg_wr ? cfg_wdata : code_q;
    prev_d   = pin_s;
    sticky_d = sticky_q;
    if (cfg_wr)      sticky_d = 1'b0;
    else if (hit)    sticky_d = 1'b1;
    else if (clr)    sticky_d = 1'b0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      prev_q   <= 1'b1;
      sticky_q <= 1'b0;
    end else begin
      if (cfg_wr) code_q <= code_d;
      prev_q   <= prev_d;
      sticky_q <= sticky_d;
    end
  end

  // Outputs
  always_comb begin
    status = is_edge ? sticky_q : lvl_stat;
    irq    = status & agg_en;
    wake   = is_edge & sticky_q & agg_en;
    clkreq = (mode != DET_OFF) & status;
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int SEL_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] agg_en,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [CODE_W-1:0]   cfg_wdata,
  input  logic                clr_we,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] irq_req,
  output logic                wake_req,
  output logic                clk_req
);

  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] wake_vec;
  logic [NUM_PINS-1:0] clkreq_vec;
  logic [NUM_PINS-1:0] pin_edge_mode;

  gpio_sync2 #(
    .WIDTH   (NUM_PINS),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (pin_sync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic pin_cfg_wr;
    logic pin_clr;
    assign pin_cfg_wr = cfg_we && (cfg_sel == SEL_W'(i));
    assign pin_clr    = clr_we && clr_mask[i];

    gpio_pin_det u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_s     (pin_sync[i]),
      .cfg_wr    (pin_cfg_wr),
      .cfg_wdata (cfg_wdata),
      .clr       (pin_clr),
      .agg_en    (agg_en[i]),
      .irq       (irq_req[i]),
      .wake      (wake_vec[i]),
      .clkreq    (clkreq_vec[i]),
      .is_edge   (pin_edge_mode[i])
    );
  end

  assign wake_req = |wake_vec;
  assign clk_req  = |clkreq_vec;

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NUM_PINS = 4,
  parameter int SEL_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [SEL_W-1:0]    cfg_sel,
  input logic [3:0]          cfg_wdata,
  input logic                clr_we,
  input logic [NUM_PINS-1:0] clr_mask,
  input logic [NUM_PINS-1:0] agg_en,
  input logic [NUM_PINS-1:0] irq_req,
  input logic                wake_req,
  input logic                clk_req,
  input logic [NUM_PINS-1:0] pin_edge_mode
);

  AST_WAKE_NEEDS_EDGE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ((irq_req & pin_edge_mode) != '0)); // R7

  AST_IRQ_RAISES_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != '0) |-> clk_req); // R8

  AST_IRQ_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~agg_en) == '0); // R6

  AST_CFG_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[3]) |=> !irq_req[$past(cfg_sel)]); // R9

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_hold
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_edge_mode[i] && irq_req[i] && !(clr_we && clr_mask[i]) &&
       !(cfg_we && (cfg_sel == SEL_W'(i))))
      |=> (irq_req[i] || !agg_en[i])); // R4
  end

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
  .NUM_PINS (NUM_PINS),
  .SEL_W    (SEL_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .cfg_sel       (cfg_sel),
  .cfg_wdata     (cfg_wdata),
  .clr_we        (clr_we),
  .clr_mask      (clr_mask),
  .agg_en        (agg_en),
  .irq_req       (irq_req),
  .wake_req      (wake_req),
  .clk_req       (clk_req),
  .pin_edge_mode (pin_edge_mode)
);

// File: tb/gpio_irq_detect_test.sv
`timescale 1ns/1ps
module gpio_irq_detect_test;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] agg_en;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [3:0]    cfg_wdata;
  logic          clr_we;
  logic [NP-1:0] clr_mask;
  logic [NP-1:0] irq_req;
  logic          wake_req;
  logic          clk_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .agg_en(agg_en),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .clr_we(clr_we), .clr_mask(clr_mask),
    .irq_req(irq_req), .wake_req(wake_req), .clk_req(clk_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pin_in[idx] = v;
  endtask

  task automatic write_code(input int idx, input logic [3:0] code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(idx); cfg_wdata = code;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic clear_pin(input int idx);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = '0; clr_mask[idx] = 1'b1;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pin_in = '1; agg_en = '1;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; clr_we = 1'b0; clr_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(3);
    chk("R1 irq after reset", irq_req, 0);
    chk("R1 wake after reset", wake_req, 0);
    chk("R1 clk_req after reset", clk_req, 0);
  endtask

  task automatic t_low_level;
    set_pin(0, 1'b0);
    wait_cyc(1);
    chk("R2 low level not yet after one edge", irq_req[0], 0);
    wait_cyc(1);
    chk("R2 low level after two edges (R1 default code)", irq_req[0], 1);
    chk("R8 clk_req with low level", clk_req, 1);
    chk("R7 no wake in level mode", wake_req, 0);
    clear_pin(0);
    chk("R4 clear ignored in level mode", irq_req[0], 1);
    set_pin(0, 1'b1);
    wait_cyc(2);
    chk("R2 low level released", irq_req[0], 0);
  endtask

  task automatic t_high_level;
    write_code(1, 4'b0001);
    wait_cyc(1);
    chk("R2 high level on high pin", irq_req[1], 1);
    @(negedge clk) agg_en[1] = 1'b0;
    #1;
    chk("R6 irq masked by agg_en", irq_req[1], 0);
    chk("R8 clk_req independent of agg_en", clk_req, 1);
    @(negedge clk) agg_en[1] = 1'b1;
    set_pin(1, 1'b0);
    wait_cyc(2);
    chk("R2 high level released", irq_req[1], 0);
    write_code(1, 4'b0100);
    set_pin(1, 1'b1);
    wait_cyc(3);
  endtask

  task automatic t_disabled;
    logic [3:0] codes [8];
    codes = '{4'b0100, 4'b0010, 4'b0011, 4'b0101, 4'b0110, 4'b0111, 4'b1000, 4'b1100};
    for (int k = 0; k < 8; k++) begin
      write_code(2, codes[k]);
      set_pin(2, 1'b0);
      wait_cyc(3);
      chk($sformatf("R5 code %b pin low irq", codes[k]), irq_req, 0);
      chk($sformatf("R5 code %b pin low clk_req", codes[k]), clk_req, 0);
      set_pin(2, 1'b1);
      wait_cyc(3);
      chk($sformatf("R5 code %b pin high irq", codes[k]), irq_req, 0);
      chk($sformatf("R5 code %b wake", codes[k]), wake_req, 0);
    end
  endtask

  task automatic t_rise;
    write_code(3, 4'b1101);
    set_pin(3, 1'b0);
    wait_cyc(3);
    chk("R3 falling ignored in rise mode", irq_req[3], 0);
    set_pin(3, 1'b1);
    wait_cyc(2);
    chk("R3 rise not yet after two edges", irq_req[3], 0);
    wait_cyc(1);
    chk("R3 rise detected", irq_req[3], 1);
    chk("R7 wake from edge mode", wake_req, 1);
    set_pin(3, 1'b0);
    wait_cyc(3);
    chk("R4 sticky after pin returns", irq_req[3], 1);
    @(negedge clk) agg_en[3] = 1'b0;
    #1;
    chk("R6 edge irq masked", irq_req[3], 0);
    chk("R7 wake masked by agg_en", wake_req, 0);
    chk("R8 clk_req kept with agg_en low", clk_req, 1);
    @(negedge clk) agg_en[3] = 1'b1;
    clear_pin(3);
    chk("R4 sticky cleared", irq_req[3], 0);
    chk("R4 wake cleared", wake_req, 0);
  endtask

  task automatic t_fall_both;
    write_code(3, 4'b1110);
    set_pin(3, 1'b1);
    wait_cyc(3);
    chk("R3 rising ignored in fall mode", irq_req[3], 0);
    set_pin(3, 1'b0);
    wait_cyc(3);
    chk("R3 fall detected", irq_req[3], 1);
    clear_pin(3);
    write_code(3, 4'b1111);
    set_pin(3, 1'b1);
    wait_cyc(3);
    chk("R3 both: rise detected", irq_req[3], 1);
    clear_pin(3);
    set_pin(3, 1'b0);
    wait_cyc(3);
    chk("R3 both: fall detected", irq_req[3], 1);
  endtask

  task automatic t_cfg_write;
    write_code(3, 4'b1111);
    chk("R9 code write clears sticky", irq_req[3], 0);
    set_pin(3, 1'b1);
    wait_cyc(3);
    clear_pin(3);
    write_code(3, 4'b0001);
    chk("R9 new level mode active next cycle", irq_req[3], 1);
    write_code(3, 4'b1101);
    wait_cyc(3);
    chk("R9 mode switch makes no edge", irq_req[3], 0);
  endtask

  task automatic t_set_wins;
    set_pin(3, 1'b0);
    wait_cyc(3);
    chk("R3 falling ignored before set/clear race", irq_req[3], 0);
    set_pin(3, 1'b1);
    @(negedge clk);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = 4'b1000;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
    #1;
    chk("R4 edge wins over same-cycle clear", irq_req[3], 1);
  endtask

  initial begin
    t_reset();
    t_low_level();
    t_high_level();
    t_disabled();
    t_rise();
    t_fall_both();
    t_cfg_write();
    t_set_wins();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule